// File: doc/BRIEF.md
# AES MixColumns and AddRoundKey Round-Tail Unit

This block finishes one middle round of AES encryption for a state held in shared memory. Software performs SubBytes and ShiftRows, places the four state columns in four column RAMs, and places the expanded key schedule in a key RAM. It then sets a start flag. While idle, the unit polls the flag word. When the flag is seen, it visits the columns in order 0 to 3. For each column it reads the column word and the matching round-key word. It multiplies the column by the fixed MixColumns matrix over GF(2^8), XORs in the key word and writes the result back into the same column RAM. After the last column it clears the flag and returns to polling.

All RAMs are synchronous and read-first: read data appears one cycle after the address is presented. A write that lands on the same edge as a read returns the old contents. Byte 0 of a column is bits 31:24 of its word. The round index is sampled when the flag is seen and stays fixed for the whole pass. One pass, from flag detection to the return to polling, takes 18 cycles.

Top module: `aes_mixkey_unit`

## Requirements
- R1: After reset the unit is idle. It presents byte address 0x00 on `col_addr` and drives `col_we` to all zeros.
- R2: While idle, a pass starts only when the column-0 read data (the word at 0x00, the flag) equals exactly 32'h1. Any other flag value, including 2, leaves the unit idle, with no write and no change to memory.
- R3: The state word of column c is read from byte address 0x04 of column RAM c. `col_addr` holds 0x04 during the read cycle and the two cycles after it, and no other word of the column RAM is read for data.
- R4: While column c is being read, `key_addr` equals 0x20 + 4*(c + 4*(r + 1)), where r is the sampled round. The round input stays within 0 to 8, so the key address stays word-aligned within 0x30 to 0xBC.
- R5: The written word is MixColumns(column) XOR key word. It goes to byte address 0x08 of column RAM c. Only the enable group of column c (`col_we[4c+3:4c]`) is asserted, and it is set to 4'b1111. MixColumns uses the matrix rows (2,3,1,1), (1,2,3,1), (1,1,2,3), (3,1,1,2), with xtime reduced by 0x11B. Byte 0 is the MSB.
- R6: Columns are processed in order 0, 1, 2, 3, each in four cycles: read, wait, compute and write. Column 0's read cycle directly follows the cycle in which the flag is detected.
- R7: After the column-3 write, the unit writes 32'h0 to address 0x00 of column RAM 0 with enable group 0 only. It then keeps address 0x00 for one settle cycle with no write, and returns to idle. The whole pass takes 18 cycles.
- R8: A change on `round_in` after the pass has started has no effect on any key address or result of that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| round_in | input | 4 | Middle-round index, 0 to 8 |
| col_addr | output | 8 | Byte address shared by the four column RAMs |
| col_rdata | input | 128 | Read data; column c at bits [32c+31:32c] |
| col_wdata | output | 32 | Write data shared by the column RAMs |
| col_we | output | 16 | Byte write enables; column c at bits [4c+3:4c] |
| key_addr | output | 8 | Byte address of the key-schedule RAM |
| key_rdata | input | 32 | Key-schedule read data |

## Verification
A wrong sequencer state shows up at the ports within one cycle of the divergence. It appears as an address off the fixed 0x04/0x08/0x00 pattern, as an enable group for the wrong column, or as a write at the wrong point in the 18-cycle pass. A wrong captured column or key word stays hidden until the write cycle of that column, two cycles later, where it corrupts `col_wdata`. A missed or doubled flag clear shows only as a missing pass or a second, unrequested pass on the following poll cycles. This is why the flag word and the result words are also read back from memory after each pass.

// File: rtl/aes_mixkey_unit.sv
module aes_mixkey_unit #(
  parameter int ADDR_W   = 8,
  parameter int NCOL     = 4,
  parameter int ROUND_W  = 4,
  parameter int FLAG_OFS = 0,
  parameter int DATA_OFS = 4,
  parameter int RES_OFS  = 8,
  parameter int KEY_BASE = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ROUND_W-1:0]    round_in,
  output logic [ADDR_W-1:0]     col_addr,
  input  logic [NCOL*32-1:0]    col_rdata,
  output logic [31:0]           col_wdata,
  output logic [NCOL*4-1:0]     col_we,
  output logic [ADDR_W-1:0]     key_addr,
  input  logic [31:0]           key_rdata
);
  localparam int COL_W = (NCOL > 1) ? $clog2(NCOL) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_LAT, S_MIX, S_WR, S_CLR, S_DONE} state_t;

  state_t             state;
  logic [COL_W-1:0]   col;
  logic [ROUND_W-1:0] rnd;
  logic [31:0]        col_q, key_q, res_q;
  logic [31:0]        flag_word;

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [31:0] mixcol(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction

  assign flag_word = col_rdata[31:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      col   <= '0;
      rnd   <= '0;
      col_q <= '0;
      key_q <= '0;
      res_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (flag_word == 32'h1) begin
          state <= S_RD;
          col   <= '0;
          rnd   <= round_in;
        end
        S_RD:  state <= S_LAT;
        S_LAT: begin
          col_q <= col_rdata[32*col +: 32];
          key_q <= key_rdata;
          state <= S_MIX;
        end
        S_MIX: begin
          res_q <= mixcol(col_q) ^ key_q;
          state <= S_WR;
        end
        S_WR: if (int'(col) == NCOL-1) state <= S_CLR;
              else begin
                col   <= col + 1'b1;
                state <= S_RD;
              end
        S_CLR:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_RD, S_LAT, S_MIX: col_addr = ADDR_W'(DATA_OFS);
      S_WR:               col_addr = ADDR_W'(RES_OFS);
      default:            col_addr = ADDR_W'(FLAG_OFS);
    endcase
  end

  always_comb begin
    col_we = '0;
    if (state == S_WR)  col_we[4*col +: 4] = 4'hF;
    if (state == S_CLR) col_we[3:0] = 4'hF;
  end

  assign col_wdata = (state == S_CLR) ? 32'h0 : res_q;
  assign key_addr  = ADDR_W'(KEY_BASE + 4 * (int'(col) + NCOL * (int'(rnd) + 1)));
endmodule

module aes_mixkey_unit_chk #(
  parameter int ADDR_W  = 8,
  parameter int NCOL    = 4,
  parameter int ROUND_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ROUND_W-1:0] round_in,
  input logic [ADDR_W-1:0]  col_addr,
  input logic [NCOL*32-1:0] col_rdata,
  input logic [31:0]        col_wdata,
  input logic [NCOL*4-1:0]  col_we,
  input logic [ADDR_W-1:0]  key_addr,
  input logic [31:0]        key_rdata
);
  logic [NCOL-1:0] grp;
  for (genvar i = 0; i < NCOL; i++) begin : g_grp
    assign grp[i] = |col_we[4*i +: 4];
    a_r5_full_group: assert property (@(posedge clk) disable iff (!rst_n)
      (col_we[4*i +: 4] == 4'h0) || (col_we[4*i +: 4] == 4'hF));
  end

  a_r5_one_column: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grp));

  a_r5_result_address: assert property (@(posedge clk) disable iff (!rst_n)
    ((|col_we) && col_addr != '0) |-> col_addr == ADDR_W'(8));

  a_r7_clear_word: assert property (@(posedge clk) disable iff (!rst_n)
    ((|col_we) && col_addr == '0) |-> (col_we == (NCOL*4)'(16'h000F) && col_wdata == 32'h0));

  a_r7_settle_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((|col_we) && col_addr == '0) |=> (col_we == '0 && col_addr == '0));

  a_r6_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((|col_we) && col_addr == ADDR_W'(8)) |->
      ($past(col_addr) == ADDR_W'(4) && $past(col_addr, 3) == ADDR_W'(4)));

  a_r4_key_window: assert property (@(posedge clk) disable iff (!rst_n)
    key_addr[1:0] == 2'b00 && key_addr >= ADDR_W'(8'h30) && key_addr <= ADDR_W'(8'hBC));
endmodule

bind aes_mixkey_unit aes_mixkey_unit_chk #(.ADDR_W(ADDR_W), .NCOL(NCOL), .ROUND_W(ROUND_W)) u_chk (.*);

// File: tb/tb_aes_mixkey_unit.sv
module tb_aes_mixkey_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   round_in = 4'd0;
  logic [7:0]   col_addr;
  logic [127:0] col_rdata;
  logic [31:0]  col_wdata;
  logic [15:0]  col_we;
  logic [7:0]   key_addr;
  logic [31:0]  key_rdata;

  always #5 clk = ~clk;

  aes_mixkey_unit dut (.*);

  logic [31:0] cmem [4][4];
  logic [31:0] kmem [64];
  logic [31:0] crd  [4];
  logic        host_we = 1'b0;
  logic        host_key = 1'b0;
  int          host_c = 0, host_a = 0;
  logic [31:0] host_d = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int ph = -1, rr = 0;

  for (genvar c = 0; c < 4; c++) begin : g_rd
    assign col_rdata[32*c +: 32] = crd[c];
  end

  always @(posedge clk) begin
    for (int c = 0; c < 4; c++) begin
      crd[c] <= cmem[c][col_addr[3:2]];
      for (int b = 0; b < 4; b++)
        if (col_we[4*c+b]) cmem[c][col_addr[3:2]][8*b +: 8] <= col_wdata[8*b +: 8];
    end
    key_rdata <= kmem[key_addr[7:2]];
    if (host_we) begin
      if (host_key) kmem[host_a] <= host_d;
      else cmem[host_c][host_a] <= host_d;
    end
  end

  function automatic logic [7:0] gmul(input logic [7:0] a, input int k);
    logic [7:0] p = 0, x = a;
    for (int i = 0; i < 2; i++) begin
      if (k[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [31:0] mixref(input logic [31:0] w);
    logic [31:0] r = 0;
    int cf [4] = '{2, 3, 1, 1};
    for (int row = 0; row < 4; row++) begin
      logic [7:0] acc = 0;
      for (int k = 0; k < 4; k++)
        acc = acc ^ gmul(w[31-8*k -: 8], cf[(k - row + 4) % 4]);
      r[31-8*row -: 8] = acc;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) ph = -1;
    else begin
      int c, s;
      c = ph / 4; s = ph % 4;
      if (ph < 0 || ph >= 16) begin
        chk(ph < 0 ? "R1/R2 idle address" : "R7 clear address", 32'(col_addr), 32'h0);
        chk(ph == 16 ? "R7 clear enables" : "R2 no write", 32'(col_we), ph == 16 ? 32'h000F : 32'h0);
        if (ph == 16) chk("R7 clear data", col_wdata, 32'h0);
      end else if (s < 3) begin
        chk("R3 read address", 32'(col_addr), 32'h4);
        chk("R6 no write while reading", 32'(col_we), 32'h0);
        if (s == 0) chk("R4/R8 key address", 32'(key_addr), 32'(32 + 4 * (c + 4 * (rr + 1))));
      end else begin
        chk("R5 result address", 32'(col_addr), 32'h8);
        chk("R5 column enables", 32'(col_we), 32'hF << (4 * c));
        chk("R5 result data", col_wdata, mixref(cmem[c][1]) ^ kmem[8 + c + 4 * (rr + 1)]);
      end
      if (ph < 0) begin
        if (crd[0] == 32'h1) begin ph = 0; rr = int'(round_in); end
      end else begin
        ph++;
        if (ph == 18) ph = -1;
      end
    end
    if (cyc > 20000) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic hw(input logic key, input int c, input int a, input logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_key = key; host_c = c; host_a = a; host_d = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic load_cols(input logic [31:0] w0, w1, w2, w3);
    hw(0, 0, 1, w0); hw(0, 1, 1, w1); hw(0, 2, 1, w2); hw(0, 3, 1, w3);
  endtask

  task automatic check_results(input string req, input int r);
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      chk(req, cmem[c][2], mixref(cmem[c][1]) ^ kmem[8 + c + 4 * (r + 1)]);
    end
    chk("R7 flag cleared", cmem[0][0], 32'h0);
  endtask

  initial begin
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 4; a++) cmem[c][a] = 32'(c * 16 + a) * 32'h01010101;
    for (int i = 0; i < 64; i++) kmem[i] = 32'(i) * 32'h9E3779B9 ^ 32'h5A3C0FF1;
    cmem[0][0] = 32'h0;
    for (int c = 0; c < 4; c++) crd[c] = '0;
    key_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset address", 32'(col_addr), 32'h0);
    chk("R1 reset enables", 32'(col_we), 32'h0);

    load_cols(32'hd4bf5d30, 32'he0b452ae, 32'hb84111f1, 32'h1e2798e5);
    hw(1, 0, 12, 32'ha0fafe17); hw(1, 0, 13, 32'h88542cb1);
    hw(1, 0, 14, 32'h23a33939); hw(1, 0, 15, 32'h2a6c7605);
    round_in = 4'd0;
    hw(0, 0, 0, 32'h1);
    repeat (24) @(posedge clk);
    @(negedge clk);
    chk("R5 known column 0", cmem[0][2], 32'ha49c7ff2);
    chk("R5 known column 1", cmem[1][2], 32'h689f352b);
    chk("R5 known column 2", cmem[2][2], 32'h6b5bea43);
    chk("R5 known column 3", cmem[3][2], 32'h026a5049);
    chk("R3 source untouched", cmem[2][1], 32'hb84111f1);
    chk("R7 flag cleared", cmem[0][0], 32'h0);

    round_in = 4'd5;
    hw(0, 0, 0, 32'h2);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R2 flag 2 ignored", cmem[0][0], 32'h2);
    chk("R2 no result change", cmem[3][2], 32'h026a5049);

    load_cols(32'h00000000, 32'hffffffff, 32'h80808080, 32'h01234567);
    round_in = 4'd8;
    hw(0, 0, 0, 32'h1);
    repeat (6) @(posedge clk);
    #1 round_in = 4'd3;
    repeat (20) @(posedge clk);
    check_results("R4/R8 round 8 results", 8);

    load_cols(32'hdb135345, 32'hf20a225c, 32'h01010101, 32'hc6c6c6c6);
    round_in = 4'd4;
    hw(0, 0, 0, 32'h1);
    repeat (24) @(posedge clk);
    check_results("R5 round 4 results", 4);
    chk("R5 classic column", mixref(32'hdb135345), 32'h8e4da1bc);

    repeat (5) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule